// File: doc/BRIEF.md
# Iterative AES-128 Block Engine

This block runs the AES-128 cipher over one 128-bit block, in either direction, with a single round datapath that is reused for all ten rounds. Data arrives one byte per cycle on an 8-bit valid/ready input and leaves the same way on an 8-bit valid/ready output. Round keys are not expanded here. The engine drives a round index to an external key store and reads the matching 128-bit round key back combinationally in the same cycle.

Area is kept small by sharing resources. A parameterised number of S-box lanes (two by default) substitutes the state a few bytes per cycle, so one SubBytes step takes eight cycles. The linear layer holds both the forward and inverse column mixing, and the latched direction picks between them. Decryption uses the straight inverse cipher. InvShiftRows and InvSubBytes commute, so the bytes are substituted in place first. One cycle then applies InvShiftRows, AddRoundKey and InvMixColumns.

The state machine has five named states. LOAD collects sixteen input bytes and moves to WHITEN on the sixteenth. WHITEN adds the first round key and moves to SUB. SUB takes eight cycles of lane substitution and moves to MIX. MIX applies the linear layer and key, then returns to SUB for rounds 1 to 9, or moves to DRAIN after round 10. DRAIN presents sixteen output bytes and returns to LOAD once the last one is taken.

Top module: `aes_iter_core`

## Requirements
- R1: After reset, and after a reset applied mid-block, in_ready is 1, out_valid is 0 and busy is 0.
- R2: An input byte is accepted on a rising edge with in_valid and in_ready both high. The first accepted byte is state byte 0, which is the most significant byte of the 128-bit block in standard column-major order. in_dec is sampled only with that first byte: 0 selects encryption and 1 selects decryption.
- R3: In encryption mode, the sixteen output bytes are the AES-128 encryption of the input block under the round keys read from the key store.
- R4: In decryption mode, the sixteen output bytes are the AES-128 decryption of the input block under the same round keys.
- R5: While busy, key_idx takes the values 0,1,…,10 in order when encrypting, and 10,9,…,0 in order when decrypting. Each value appears as one contiguous run.
- R6: out_valid first rises exactly 91 rising edges after the edge that accepts the sixteenth input byte.
- R7: From the sixteenth accepted byte until the last output byte is taken, in_ready is 0 and in_valid and in_data have no effect on the result.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged. Output bytes leave in state byte order, byte 0 first.
- R9: On the edge that takes the sixteenth output byte, busy falls to 0 and in_ready rises to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Engine accepts an input byte |
| in_data | input | 8 | Input byte |
| in_dec | input | 1 | Direction for the block, sampled with byte 0 (1 = decrypt) |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Output byte |
| busy | output | 1 | Block in progress, new input blocked |
| key_idx | output | 4 | Round key index to the key store |
| key_data | input | 128 | Round key for key_idx, byte 0 in the top bits |

## Verification
A wrong lane index, a wrong round count or a wrong S-box or column-mixing entry spreads through the remaining rounds. It shows up as a completely wrong output block as soon as the first output byte leaves. A sequencing fault in the state machine shows up earlier. It appears either as a key_idx sequence that skips, repeats or runs backward, or as out_valid rising at some edge other than 91 after the last input byte. A fault in the output stage appears within one cycle of a stall, as out_data changing or out_valid dropping while out_ready is low.

// File: rtl/aes_rk_pkg.sv
package aes_rk_pkg;

    localparam int BYTES = 16;
    typedef logic [BYTES-1:0][7:0] blk_t;

    // storage position of state byte i (byte 0 sits in the top bits)
    function automatic int bpos(input int i);
        return BYTES - 1 - i;
    endfunction

    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        logic [7:0] s;
        p = 8'h00;
        s = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ s;
            s = xt(s);
        end
        return p;
    endfunction

    // x^254 by repeated squaring; maps 0 to 0
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] sq;
        logic [7:0] r;
        sq = x;
        r  = 8'h01;
        for (int k = 1; k < 8; k++) begin
            sq = gmul(sq, sq);
            r  = gmul(r, sq);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl(input logic [7:0] b, input int n);
        return 8'((b << n) | (b >> (8 - n)));
    endfunction

    function automatic logic [7:0] sub_fwd(input logic [7:0] x);
        logic [7:0] v;
        v = gf_inv(x);
        return v ^ rotl(v, 1) ^ rotl(v, 2) ^ rotl(v, 3) ^ rotl(v, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] sub_inv(input logic [7:0] x);
        return gf_inv(rotl(x, 1) ^ rotl(x, 3) ^ rotl(x, 6) ^ 8'h05);
    endfunction

    function automatic blk_t shift_rows(input blk_t b, input logic inv);
        blk_t o;
        int   src;
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                src = inv ? ((c - r + 4) % 4) : ((c + r) % 4);
                o[bpos(r + 4 * c)] = b[bpos(r + 4 * src)];
            end
        end
        return o;
    endfunction

    function automatic blk_t mix_blk(input blk_t b, input logic inv);
        blk_t       o;
        logic [7:0] k [4];
        logic [7:0] acc;
        if (inv) begin
            k[0] = 8'h0e; k[1] = 8'h0b; k[2] = 8'h0d; k[3] = 8'h09;
        end else begin
            k[0] = 8'h02; k[1] = 8'h03; k[2] = 8'h01; k[3] = 8'h01;
        end
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                acc = 8'h00;
                for (int j = 0; j < 4; j++)
                    acc = acc ^ gmul(b[bpos(4 * c + j)], k[(j - r + 4) % 4]);
                o[bpos(4 * c + r)] = acc;
            end
        end
        return o;
    endfunction

endpackage

// File: rtl/aes_sbox_lane.sv
module aes_sbox_lane
    import aes_rk_pkg::*;
(
    input  logic       dec_i,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    assign dout = dec_i ? sub_inv(din) : sub_fwd(din);
endmodule

// File: rtl/aes_lin_layer.sv
module aes_lin_layer
    import aes_rk_pkg::*;
(
    input  blk_t   blk_i,
    input  blk_t   rk_i,
    input  logic   dec_i,
    input  logic   last_i,
    output blk_t   blk_o
);
    blk_t shifted;
    blk_t keyed;

    always_comb begin
        shifted = shift_rows(blk_i, dec_i);
        if (dec_i) begin
            // inverse round: shift, add key, then unmix
            keyed = shifted ^ rk_i;
            blk_o = last_i ? keyed : mix_blk(keyed, 1'b1);
        end else begin
            keyed = last_i ? shifted : mix_blk(shifted, 1'b0);
            blk_o = keyed ^ rk_i;
        end
    end
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
    import aes_rk_pkg::*;
#(
    parameter int NR    = 10,
    parameter int LANES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [7:0]                     in_data,
    input  logic                           in_dec,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic [7:0]                     out_data,
    output logic                           busy,
    output logic [$clog2(NR+1)-1:0]        key_idx,
    input  logic [8*BYTES-1:0]             key_data
);
    localparam int RW        = $clog2(NR + 1);
    localparam int CW        = $clog2(BYTES);
    localparam int SUB_STEPS = BYTES / LANES;
    localparam int SW        = $clog2(SUB_STEPS);

    typedef enum logic [2:0] {S_LOAD, S_WHITEN, S_SUB, S_MIX, S_DRAIN} st_e;

    st_e             st_q, st_d;
    blk_t            blk_q, blk_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [RW-1:0]   rnd_q, rnd_d;
    logic            dec_q, dec_d;
    blk_t            rk;
    blk_t            lin_out;
    logic [7:0]      sub_in  [LANES];
    logic [7:0]      sub_out [LANES];

    assign rk      = blk_t'(key_data);
    assign key_idx = dec_q ? (RW'(NR) - rnd_q) : rnd_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign sub_in[l] = blk_q[bpos(int'(cnt_q[SW-1:0]) * LANES + l)];
        aes_sbox_lane u_lane (.dec_i(dec_q), .din(sub_in[l]), .dout(sub_out[l]));
    end

    aes_lin_layer u_lin (
        .blk_i  (blk_q),
        .rk_i   (rk),
        .dec_i  (dec_q),
        .last_i (rnd_q == RW'(NR)),
        .blk_o  (lin_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_LOAD;
            blk_q <= '0;
            cnt_q <= '0;
            rnd_q <= '0;
            dec_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            blk_q <= blk_d;
            cnt_q <= cnt_d;
            rnd_q <= rnd_d;
            dec_q <= dec_d;
        end
    end

    // next state and datapath
    always_comb begin
        st_d  = st_q;
        blk_d = blk_q;
        cnt_d = cnt_q;
        rnd_d = rnd_q;
        dec_d = dec_q;
        unique case (st_q)
            S_LOAD: begin
                if (in_valid) begin
                    blk_d[CW'(BYTES - 1) - cnt_q] = in_data;
                    if (cnt_q == '0) dec_d = in_dec;
                    if (cnt_q == CW'(BYTES - 1)) begin
                        cnt_d = '0;
                        st_d  = S_WHITEN;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            S_WHITEN: begin
                blk_d = blk_q ^ rk;
                rnd_d = RW'(1);
                cnt_d = '0;
                st_d  = S_SUB;
            end
            S_SUB: begin
                for (int l = 0; l < LANES; l++)
                    blk_d[bpos(int'(cnt_q[SW-1:0]) * LANES + l)] = sub_out[l];
                if (cnt_q == CW'(SUB_STEPS - 1)) begin
                    cnt_d = '0;
                    st_d  = S_MIX;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_MIX: begin
                blk_d = lin_out;
                if (rnd_q == RW'(NR)) begin
                    cnt_d = '0;
                    st_d  = S_DRAIN;
                end else begin
                    rnd_d = rnd_q + 1'b1;
                    st_d  = S_SUB;
                end
            end
            S_DRAIN: begin
                if (out_ready) begin
                    if (cnt_q == CW'(BYTES - 1)) begin
                        cnt_d = '0;
                        rnd_d = '0;
                        st_d  = S_LOAD;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: st_d = S_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = (st_q == S_LOAD);
        out_valid = (st_q == S_DRAIN);
        busy      = (st_q != S_LOAD);
        out_data  = blk_q[CW'(BYTES - 1) - cnt_q];
    end

    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_key_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && key_idx != $past(key_idx)) |->
        (dec_q ? (key_idx == $past(key_idx) - RW'(1))
               : (key_idx == $past(key_idx) + RW'(1))));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && cnt_q == CW'(BYTES - 1)) |=> (!busy && in_ready));

    // encrypt lane output must undo through the inverse table (R3)
    p_sbox_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SUB && !dec_q) |-> (sub_inv(sub_out[0]) == sub_in[0]));

    // decrypt lane output must undo through the forward table (R4)
    p_sbox_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SUB && dec_q) |-> (sub_fwd(sub_out[0]) == sub_in[0]));

    // a full encrypt round must be invertible back to its input (R3)
    p_mix_undo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_MIX && !dec_q && rnd_q != RW'(NR)) |->
        (shift_rows(mix_blk(lin_out ^ rk, 1'b1), 1'b1) == blk_q));

endmodule

// File: tb/sim_aes_iter_core.sv
module sim_aes_iter_core;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   in_data = 8'h00;
    logic         in_dec = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [7:0]   out_data;
    logic         busy;
    logic [3:0]   key_idx;
    logic [127:0] key_data;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    logic [7:0]   sb [256];
    logic [127:0] rks [11];
    logic [3:0]   seq [16];
    int           seq_len = 0;
    bit           mon_en = 0;

    localparam logic [3:0][127:0] V_KEY = {
        128'h2b7e151628aed2a6abf7158809cf4f3c,
        128'h2b7e151628aed2a6abf7158809cf4f3c,
        128'h000102030405060708090a0b0c0d0e0f,
        128'h000102030405060708090a0b0c0d0e0f};
    localparam logic [3:0][127:0] V_IN = {
        128'h3925841d02dc09fbdc118597196a0b32,
        128'h3243f6a8885a308d313198a2e0370734,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a,
        128'h00112233445566778899aabbccddeeff};
    localparam logic [3:0][127:0] V_OUT = {
        128'h3243f6a8885a308d313198a2e0370734,
        128'h3925841d02dc09fbdc118597196a0b32,
        128'h00112233445566778899aabbccddeeff,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a};
    localparam logic [3:0] V_DEC = 4'b1010;

    aes_iter_core u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_dec(in_dec), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .busy(busy),
        .key_idx(key_idx), .key_data(key_data));

    always #4 clk = ~clk;

    assign key_data = (key_idx <= 4'd10) ? rks[key_idx] : 128'h0;

    always @(negedge clk) begin
        if (mon_en && busy && seq_len < 16 &&
            (seq_len == 0 || key_idx != seq[seq_len-1])) begin
            seq[seq_len] = key_idx;
            seq_len++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] s = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= s;
            s = {s[6:0], 1'b0} ^ (s[7] ? 8'h1b : 8'h00);
        end
        return p;
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] v = 0;
            logic [7:0] o;
            for (int y = 1; y < 256; y++)
                if (tmul(8'(x), 8'(y)) == 8'h01) v = 8'(y);
            for (int i = 0; i < 8; i++)
                o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8];
            sb[x] = o ^ 8'h63;
        end
    endtask

    task automatic expand(input logic [127:0] key);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
                rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++) rks[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    // R2: direction driven only valid on byte 0, inverted afterwards
    task automatic send(input logic [127:0] d, input logic dec, input bit noise,
                        output int lat, output bit ready_bad);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = d[127-8*i -: 8];
            in_dec   = (i == 0) ? dec : ~dec;
            @(posedge clk);
        end
        lat = 0;
        ready_bad = 0;
        forever begin
            @(negedge clk);
            in_valid = noise;
            in_data  = 8'ha5 ^ 8'(lat);
            in_dec   = ~in_dec;
            if (in_ready) ready_bad = 1;
            if (out_valid || lat > 300) break;
            @(posedge clk);
            lat++;
        end
    endtask

    task automatic recv(output logic [127:0] r, input int stall_at);
        logic [7:0] held;
        for (int i = 0; i < 16; i++) begin
            if (i == stall_at) begin
                held = out_data;
                repeat (3) @(negedge clk);
                chk(out_valid && out_data == held, "R8 stall hold",
                    {out_valid, out_data}, {1'b1, held});
            end
            r[127-8*i -: 8] = out_data;
            if (i == 15) in_valid = 1'b0;
            out_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            out_ready = 1'b0;
        end
    endtask

    task automatic run_vec(input int v, input int stall_at, input bit noise);
        int           lat;
        bit           rb;
        bit           ok;
        logic [127:0] res;
        logic         dec = V_DEC[v];
        expand(V_KEY[v]);
        seq_len = 0;
        mon_en  = 1;
        send(V_IN[v], dec, noise, lat, rb);
        chk(lat == 91, "R6 latency", 128'(lat), 128'd91);
        chk(!rb, "R7 in_ready low while busy", 128'(rb), 128'd0);
        recv(res, stall_at);
        mon_en = 0;
        chk(res == V_OUT[v], dec ? "R4 R2 R8 decrypt" : "R3 R2 R8 encrypt", res, V_OUT[v]);
        ok = (seq_len == 11);
        for (int i = 0; i < 11; i++)
            if (seq[i] != (dec ? 4'(10 - i) : 4'(i))) ok = 0;
        chk(ok, "R5 key index order", 128'(seq_len), 128'd11);
        chk(!busy && in_ready && !out_valid, "R9 release",
            {busy, in_ready, out_valid}, 3'b010);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        build_sbox();
        repeat (3) @(negedge clk);
        chk(in_ready && !out_valid && !busy, "R1 reset state",
            {in_ready, out_valid, busy}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid && !busy, "R1 after release",
            {in_ready, out_valid, busy}, 3'b100);

        // vector table walk
        for (int v = 0; v < 4; v++)
            run_vec(v, (v == 1) ? 5 : ((v == 2) ? 0 : 16), (v % 2) == 1);

        // R1: reset in the middle of a block
        expand(V_KEY[0]);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'(i * 7);
            in_dec   = 1'b0;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(in_ready && !out_valid && !busy, "R1 mid-block reset",
            {in_ready, out_valid, busy}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        run_vec(0, 15, 1'b1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule